// File: doc/BRIEF.md
# Serial programming access sequencer

This block sits between the byte layer of a serial programming link and the chip's internal memory-bus port. It receives command bytes, decodes each one, and moves a single operand byte to or from one of three address spaces: a data space reached indirectly through a 16-bit pointer held in the block, an I/O space addressed directly by six bits packed into the command, and a small control/status space addressed directly by four command bits. A key command collects the eight bytes that follow it into a key register and signals when the last one has arrived. The key value itself is not checked here.

The byte layer reports reception faults (bad parity, bad framing), the reception of a BREAK character, and a collision while transmitting. Any of these aborts the current command. Parity, framing and collision faults leave the sequencer in a sticky error state in which every command byte is ignored. A BREAK aborts whatever is in progress and returns the sequencer to idle from any state, so a host that has lost track of the protocol recovers by sending two BREAK characters.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block starts working two clock cycles after `rst_n` rises.

Top module: `prog_access_seq`

## Requirements
- R1: After reset the block is idle, not in error, the pointer is 0x0000, and `tx_valid`, `bus_rd`, `bus_wr` and `key_valid` are low.
- R2: Command 0110_100a writes the next received byte into one byte of the pointer: a=0 selects bits 7:0 and a=1 selects bits 15:8. No bus strobe is issued.
- R3: Command 0110_0000 writes the next received byte to the data space (bus_space 0) at the pointer address, with `bus_wr` high during the cycle in which that byte is presented. Command 0110_0100 does the same and then increments the pointer by one.
- R4: Command 0010_0000 raises `bus_rd` for one cycle in the cycle after the command byte, addressing the data space at the pointer. In the following cycle `tx_valid` pulses with the byte that was read. Command 0010_0100 does the same and then increments the pointer by one.
- R5: Command 0aa1_aaaa reads, and command 1aa1_aaaa writes, the I/O space (bus_space 1). The address is {command[6:5], command[3:0]}, zero-extended. Reads return the data through `tx_valid`/`tx_byte` with the same timing as R4. Writes take the next received byte.
- R6: Command 1000_aaaa reads, and command 1100_aaaa writes, the control/status space (bus_space 2) at address command[3:0]. Timing is the same as R4 and R3.
- R7: Command 1110_0000 captures the next eight received bytes into `key_out`, with the first byte in bits 7:0 and each later byte one byte position higher. `key_valid` pulses for one cycle in the cycle after the eighth byte. No bus strobe is issued.
- R8: Any command byte not listed in R2 to R7 puts the block into the error state.
- R9: A parity error, frame error or transmit collision aborts the command in progress without a bus strobe, `tx_valid` or `key_valid`, and enters the error state from the next cycle.
- R10: In the error state all received bytes are ignored: no bus strobe and no transmit byte. The block stays in the error state until a BREAK is received.
- R11: A BREAK in any state aborts the current command and returns the block to idle in the next cycle. After two BREAKs in a row the block is always idle and decodes the next byte as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| rx_parity_err | input | 1 | Parity fault on reception |
| rx_frame_err | input | 1 | Framing fault on reception |
| rx_break | input | 1 | BREAK character received |
| tx_collision | input | 1 | Collision seen while transmitting |
| tx_valid | output | 1 | One-cycle pulse: `tx_byte` holds a byte to send |
| tx_byte | output | 8 | Byte to transmit |
| bus_rd | output | 1 | Read strobe toward the memory bus |
| bus_wr | output | 1 | Write strobe toward the memory bus |
| bus_space | output | 2 | Target space: 0 data, 1 I/O, 2 control/status |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the cycle `bus_rd` is high |
| key_out | output | 64 | Captured key bytes |
| key_valid | output | 1 | One-cycle pulse after the last key byte |
| err_state | output | 1 | High while the block is in the error state |

## Verification
A wrong pointer shows up on the first indirect access after it: `bus_addr` is wrong in the very cycle the strobe fires, and the returned byte reaches `tx_byte` one cycle later. A mis-packed direct address is visible on `bus_addr` in the strobe cycle itself. A wrong sequencer state shows in one of three ways: as a strobe where none is allowed, as a missing strobe on the next operand byte, or as `err_state` differing from the expected value one cycle after the fault or BREAK. A wrong key byte count is exposed by `key_valid` pulsing too early or not at all, and by bytes landing in the wrong lanes of `key_out`.

// File: rtl/prog_access_pkg.sv
package prog_access_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WDATA,
    ST_KEY,
    ST_ERR
  } seq_state_e;

  typedef enum logic [3:0] {
    OP_LD_IND,
    OP_ST_IND,
    OP_ST_PTR,
    OP_IO_IN,
    OP_IO_OUT,
    OP_CS_LD,
    OP_CS_ST,
    OP_KEY,
    OP_BAD
  } op_kind_e;

  typedef enum logic [1:0] {
    SP_DATA = 2'd0,
    SP_IO   = 2'd1,
    SP_CS   = 2'd2
  } space_e;

  typedef struct packed {
    op_kind_e    kind;
    logic        post_inc;
    logic        ptr_hi;
    logic [5:0]  daddr;
  } op_dec_t;

endpackage

// File: rtl/prog_op_decode.sv
module prog_op_decode
  import prog_access_pkg::*;
(
  input  logic [7:0] opcode,
  output op_dec_t    dec
);

  always_comb begin
    dec          = '0;
    dec.kind     = OP_BAD;
    dec.daddr    = {opcode[6:5], opcode[3:0]};
    if (opcode[4]) begin
      // bit 4 set marks the I/O pair; bit 7 chooses direction
      dec.kind = opcode[7] ? OP_IO_OUT : OP_IO_IN;
    end else begin
      case (opcode)
        8'h20, 8'h24: begin
          dec.kind     = OP_LD_IND;
          dec.post_inc = opcode[2];
        end
        8'h60, 8'h64: begin
          dec.kind     = OP_ST_IND;
          dec.post_inc = opcode[2];
        end
        8'h68, 8'h69: begin
          dec.kind   = OP_ST_PTR;
          dec.ptr_hi = opcode[0];
        end
        8'hE0: dec.kind = OP_KEY;
        default: begin
          if (opcode[7:4] == 4'h8) begin
            dec.kind  = OP_CS_LD;
            dec.daddr = {2'b00, opcode[3:0]};
          end else if (opcode[7:4] == 4'hC) begin
            dec.kind  = OP_CS_ST;
            dec.daddr = {2'b00, opcode[3:0]};
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/prog_ptr_reg.sv
module prog_ptr_reg #(
  parameter int PTR_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(PTR_W/8)-1:0] wr_lane,
  input  logic [7:0]                wr_data,
  input  logic                      inc_en,
  output logic [PTR_W-1:0]          ptr
);

  localparam int NLANES = PTR_W / 8;
  localparam int LANE_W = $clog2(NLANES);

  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (inc_en) ptr_d = ptr_q + PTR_W'(1);
    for (int g = 0; g < NLANES; g++) begin
      if (wr_en && (wr_lane == LANE_W'(g))) ptr_d[g*8 +: 8] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ptr_q <= '0;
    else if (wr_en || inc_en)  ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  AST_PTR_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !wr_en) |=> (ptr_q == $past(ptr_q) + PTR_W'(1))); // R3

endmodule

// File: rtl/prog_key_capture.sv
module prog_key_capture #(
  parameter int KEY_BYTES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     byte_en,
  input  logic [7:0]               byte_in,
  output logic                     last_byte,
  output logic [KEY_BYTES*8-1:0]   key,
  output logic                     key_valid
);

  localparam int KEY_W = KEY_BYTES * 8;
  localparam int CNT_W = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;

  logic [KEY_W-1:0] key_q, key_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             kv_q, kv_d;

  assign last_byte = (cnt_q == CNT_W'(KEY_BYTES - 1));

  always_comb begin
    key_d = key_q;
    cnt_d = cnt_q;
    kv_d  = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (byte_en) begin
      key_d = {byte_in, key_q[KEY_W-1:8]};
      cnt_d = last_byte ? '0 : cnt_q + CNT_W'(1);
      kv_d  = last_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      cnt_q <= '0;
      kv_q  <= 1'b0;
    end else begin
      if (byte_en && !clr) key_q <= key_d;
      if (byte_en || clr)  cnt_q <= cnt_d;
      kv_q <= kv_d;
    end
  end

  assign key       = key_q;
  assign key_valid = kv_q;

  AST_KEY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    kv_q |-> (cnt_q == '0)); // R7

endmodule

// File: rtl/prog_access_seq.sv
module prog_access_seq
  import prog_access_pkg::*;
#(
  parameter int PTR_W     = 16,
  parameter int KEY_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_byte,
  input  logic                   rx_parity_err,
  input  logic                   rx_frame_err,
  input  logic                   rx_break,
  input  logic                   tx_collision,
  output logic                   tx_valid,
  output logic [7:0]             tx_byte,
  output logic                   bus_rd,
  output logic                   bus_wr,
  output logic [1:0]             bus_space,
  output logic [PTR_W-1:0]       bus_addr,
  output logic [7:0]             bus_wdata,
  input  logic [7:0]             bus_rdata,
  output logic [KEY_BYTES*8-1:0] key_out,
  output logic                   key_valid,
  output logic                   err_state
);

  localparam int LANE_W = $clog2(PTR_W / 8);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  seq_state_e state_q, state_d;
  op_dec_t    op_q, op_d, dec;
  logic       tx_valid_q, tx_valid_d;
  logic [7:0] tx_byte_q, tx_byte_d;
  logic       ptr_wr, ptr_inc, key_en, key_clr, key_last;
  logic       rd_c, wr_c;
  logic       exc_err;
  space_e     space_c;
  logic [PTR_W-1:0] ptr;

  prog_op_decode u_dec (
    .opcode (rx_byte),
    .dec    (dec)
  );

  prog_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (ptr_wr),
    .wr_lane (LANE_W'(op_q.ptr_hi)),
    .wr_data (rx_byte),
    .inc_en  (ptr_inc),
    .ptr     (ptr)
  );

  prog_key_capture #(.KEY_BYTES(KEY_BYTES)) u_key (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr       (key_clr),
    .byte_en   (key_en),
    .byte_in   (rx_byte),
    .last_byte (key_last),
    .key       (key_out),
    .key_valid (key_valid)
  );

  assign exc_err = rx_parity_err | rx_frame_err | tx_collision;

  always_comb begin
    case (op_q.kind)
      OP_IO_IN, OP_IO_OUT: space_c = SP_IO;
      OP_CS_LD, OP_CS_ST:  space_c = SP_CS;
      default:             space_c = SP_DATA;
    endcase
  end

  always_comb begin
    state_d    = state_q;
    op_d       = op_q;
    tx_valid_d = 1'b0;
    tx_byte_d  = tx_byte_q;
    ptr_wr     = 1'b0;
    ptr_inc    = 1'b0;
    key_en     = 1'b0;
    key_clr    = 1'b0;
    rd_c       = 1'b0;
    wr_c       = 1'b0;
    if (rx_break) begin
      state_d = ST_IDLE;
      key_clr = 1'b1;
    end else if (exc_err) begin
      state_d = ST_ERR;
      key_clr = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (rx_valid) begin
            op_d = dec;
            case (dec.kind)
              OP_LD_IND, OP_IO_IN, OP_CS_LD:            state_d = ST_READ;
              OP_ST_IND, OP_ST_PTR, OP_IO_OUT, OP_CS_ST: state_d = ST_WDATA;
              OP_KEY: begin
                state_d = ST_KEY;
                key_clr = 1'b1;
              end
              default: state_d = ST_ERR;
            endcase
          end
        end
        ST_READ: begin
          rd_c       = 1'b1;
          tx_valid_d = 1'b1;
          tx_byte_d  = bus_rdata;
          ptr_inc    = (op_q.kind == OP_LD_IND) && op_q.post_inc;
          state_d    = ST_IDLE;
        end
        ST_WDATA: begin
          if (rx_valid) begin
            if (op_q.kind == OP_ST_PTR) ptr_wr = 1'b1;
            else                        wr_c   = 1'b1;
            ptr_inc = (op_q.kind == OP_ST_IND) && op_q.post_inc;
            state_d = ST_IDLE;
          end
        end
        ST_KEY: begin
          if (rx_valid) begin
            key_en = 1'b1;
            if (key_last) state_d = ST_IDLE;
          end
        end
        default: state_d = ST_ERR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q    <= ST_IDLE;
      op_q       <= '0;
      tx_valid_q <= 1'b0;
      tx_byte_q  <= '0;
    end else begin
      state_q    <= state_d;
      op_q       <= op_d;
      tx_valid_q <= tx_valid_d;
      if (tx_valid_d) tx_byte_q <= tx_byte_d;
    end
  end

  assign tx_valid  = tx_valid_q;
  assign tx_byte   = tx_byte_q;
  assign bus_rd    = rd_c;
  assign bus_wr    = wr_c;
  assign bus_space = space_c;
  assign bus_addr  = (space_c == SP_DATA) ? ptr : PTR_W'(op_q.daddr);
  assign bus_wdata = rx_byte;
  assign err_state = (state_q == ST_ERR);

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (err_state && !rx_break) |=> err_state); // R10
  AST_NO_STROBE_IN_ERR: assert property (@(posedge clk) disable iff (!rst_n_s)
    err_state |-> (!bus_rd && !bus_wr)); // R10
  AST_BREAK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    rx_break |=> (state_q == ST_IDLE)); // R11
  AST_FAULT_TO_ERR: assert property (@(posedge clk) disable iff (!rst_n_s)
    (exc_err && !rx_break) |=> err_state); // R9
  AST_FAULT_NO_TX: assert property (@(posedge clk) disable iff (!rst_n_s)
    exc_err |=> !tx_valid); // R9
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_rd |=> (tx_valid && tx_byte == $past(bus_rdata))); // R4

endmodule

// File: tb/prog_access_seq_tb_top.sv
module prog_access_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, rx_parity_err, rx_frame_err, rx_break, tx_collision;
  logic [7:0]  rx_byte;
  logic        tx_valid, bus_rd, bus_wr, key_valid, err_state;
  logic [7:0]  tx_byte, bus_wdata, bus_rdata;
  logic [1:0]  bus_space;
  logic [15:0] bus_addr;
  logic [63:0] key_out;

  int checks = 0;
  int fails  = 0;

  logic [7:0] ds_mem [0:255];
  logic [7:0] io_mem [0:63];
  logic [7:0] cs_mem [0:15];

  int          tx_cnt = 0, wr_cnt = 0, rd_cnt = 0, kv_cnt = 0;
  logic [7:0]  last_tx = 8'h00, last_wdata = 8'h00;
  logic [1:0]  last_wspace = 2'd0, last_rspace = 2'd0;
  logic [15:0] last_waddr = 16'h0, last_raddr = 16'h0;

  always #4 clk = ~clk;

  prog_access_seq dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_byte       (rx_byte),
    .rx_parity_err (rx_parity_err),
    .rx_frame_err  (rx_frame_err),
    .rx_break      (rx_break),
    .tx_collision  (tx_collision),
    .tx_valid      (tx_valid),
    .tx_byte       (tx_byte),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_space     (bus_space),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .key_out       (key_out),
    .key_valid     (key_valid),
    .err_state     (err_state)
  );

  always_comb begin
    case (bus_space)
      2'd1:    bus_rdata = io_mem[bus_addr[5:0]];
      2'd2:    bus_rdata = cs_mem[bus_addr[3:0]];
      default: bus_rdata = ds_mem[bus_addr[7:0]];
    endcase
  end

  // observation point: a quarter cycle after the falling edge
  always begin
    @(negedge clk);
    #2;
    if (tx_valid) begin tx_cnt++; last_tx = tx_byte; end
    if (key_valid) kv_cnt++;
    if (bus_rd) begin rd_cnt++; last_rspace = bus_space; last_raddr = bus_addr; end
    if (bus_wr) begin
      wr_cnt++; last_wspace = bus_space; last_waddr = bus_addr; last_wdata = bus_wdata;
      case (bus_space)
        2'd1:    io_mem[bus_addr[5:0]] = bus_wdata;
        2'd2:    cs_mem[bus_addr[3:0]] = bus_wdata;
        default: ds_mem[bus_addr[7:0]] = bus_wdata;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_break();
    @(negedge clk);
    rx_break = 1'b1;
    @(negedge clk);
    rx_break = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] op, input logic [7:0] d);
    send_byte(op);
    send_byte(d);
    @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] op);
    send_byte(op);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(err_state == 1'b0, "R1 err_state", err_state, 0);
    check(tx_cnt == 0 && wr_cnt == 0 && rd_cnt == 0 && kv_cnt == 0, "R1 idle strobes",
          tx_cnt + wr_cnt + rd_cnt + kv_cnt, 0);
    // pointer reset value seen through an indirect load
    ds_mem[8'h00] = 8'hC7;
    do_read(8'h20);
    check(last_raddr == 16'h0000 && last_rspace == 2'd0, "R1 pointer reset", last_raddr, 0);
    check(last_tx == 8'hC7, "R1 read at zero", last_tx, 8'hC7);
  endtask

  task automatic t_ptr_and_store();
    int w0;
    w0 = wr_cnt;
    do_write(8'h68, 8'h34);
    do_write(8'h69, 8'h12);
    check(wr_cnt == w0, "R2 no bus strobe", wr_cnt, w0);
    do_write(8'h60, 8'hA5);
    check(last_wspace == 2'd0 && last_waddr == 16'h1234 && last_wdata == 8'hA5,
          "R2 R3 store at pointer", {last_wspace, last_waddr, last_wdata}, {2'd0, 16'h1234, 8'hA5});
    do_write(8'h64, 8'h11);
    check(last_waddr == 16'h1234 && last_wdata == 8'h11, "R3 post-inc store addr",
          last_waddr, 16'h1234);
    do_write(8'h60, 8'h22);
    check(last_waddr == 16'h1235 && last_wdata == 8'h22, "R3 pointer incremented",
          last_waddr, 16'h1235);
  endtask

  task automatic t_load();
    int t0;
    ds_mem[8'h36] = 8'h5C;
    t0 = tx_cnt;
    do_read(8'h20);
    check(last_tx == 8'h22 && tx_cnt == t0 + 1, "R4 load no inc", last_tx, 8'h22);
    do_read(8'h20);
    check(last_raddr == 16'h1235, "R4 pointer unchanged", last_raddr, 16'h1235);
    do_read(8'h24);
    check(last_tx == 8'h22 && last_raddr == 16'h1235, "R4 post-inc load data", last_tx, 8'h22);
    do_read(8'h20);
    check(last_tx == 8'h5C && last_raddr == 16'h1236, "R4 post-inc advanced", last_raddr, 16'h1236);
  endtask

  task automatic t_io();
    do_write(8'hB5, 8'h3C);
    check(last_wspace == 2'd1 && last_waddr == 16'h0015 && last_wdata == 8'h3C,
          "R5 out packed addr", {last_wspace, last_waddr}, {2'd1, 16'h0015});
    io_mem[6'h2A] = 8'h77;
    do_read(8'h5A);
    check(last_rspace == 2'd1 && last_raddr == 16'h002A, "R5 in packed addr",
          {last_rspace, last_raddr}, {2'd1, 16'h002A});
    check(last_tx == 8'h77, "R5 in data", last_tx, 8'h77);
  endtask

  task automatic t_cs();
    do_write(8'hC3, 8'h9E);
    check(last_wspace == 2'd2 && last_waddr == 16'h0003, "R6 cs store addr",
          {last_wspace, last_waddr}, {2'd2, 16'h0003});
    do_read(8'h83);
    check(last_tx == 8'h9E && last_rspace == 2'd2, "R6 cs load", last_tx, 8'h9E);
  endtask

  task automatic t_key(input logic [7:0] base);
    int k0, w0;
    logic [63:0] exp;
    k0 = kv_cnt;
    w0 = wr_cnt;
    send_byte(8'hE0);
    for (int i = 0; i < 8; i++) begin
      send_byte(base + 8'(i));
      exp[i*8 +: 8] = base + 8'(i);
      if (i == 6) check(kv_cnt == k0, "R7 no early key_valid", kv_cnt, k0);
    end
    @(negedge clk);
    check(kv_cnt == k0 + 1, "R7 key_valid pulse", kv_cnt, k0 + 1);
    check(key_out == exp, "R7 key byte order", key_out, exp);
    check(wr_cnt == w0, "R7 no bus write", wr_cnt, w0);
  endtask

  task automatic t_bad_opcode();
    int w0;
    send_byte(8'h00);
    @(negedge clk);
    check(err_state == 1'b1, "R8 undefined opcode", err_state, 1);
    w0 = wr_cnt;
    do_write(8'h60, 8'h44);
    do_write(8'hC1, 8'h44);
    check(wr_cnt == w0 && err_state == 1'b1, "R10 ignored in error", wr_cnt, w0);
    send_break();
    check(err_state == 1'b0, "R11 break leaves error", err_state, 0);
    do_write(8'hC4, 8'h61);
    check(last_waddr == 16'h0004 && last_wdata == 8'h61, "R11 decode after break",
          last_waddr, 16'h0004);
  endtask

  task automatic t_parity_mid_write();
    int w0;
    w0 = wr_cnt;
    send_byte(8'hC5);
    @(negedge clk);
    rx_parity_err = 1'b1;
    @(negedge clk);
    rx_parity_err = 1'b0;
    check(err_state == 1'b1, "R9 parity to error", err_state, 1);
    send_byte(8'h55);
    @(negedge clk);
    check(wr_cnt == w0, "R9 aborted write", wr_cnt, w0);
    send_break();
  endtask

  task automatic t_collision_read();
    int t0, r0;
    t0 = tx_cnt;
    r0 = rd_cnt;
    send_byte(8'h83);
    tx_collision = 1'b1;
    @(negedge clk);
    tx_collision = 1'b0;
    @(negedge clk);
    check(tx_cnt == t0 && rd_cnt == r0, "R9 collision no tx", tx_cnt, t0);
    check(err_state == 1'b1, "R9 collision to error", err_state, 1);
    send_break();
  endtask

  task automatic t_frame_in_key();
    int k0;
    k0 = kv_cnt;
    send_byte(8'hE0);
    send_byte(8'hAA);
    send_byte(8'hBB);
    @(negedge clk);
    rx_frame_err = 1'b1;
    @(negedge clk);
    rx_frame_err = 1'b0;
    for (int i = 0; i < 6; i++) send_byte(8'hCC);
    @(negedge clk);
    check(kv_cnt == k0 && err_state == 1'b1, "R9 frame aborts key", kv_cnt, k0);
    send_break();
    t_key(8'h40);
  endtask

  task automatic t_two_breaks();
    send_break();
    send_break();
    check(err_state == 1'b0, "R11 two breaks from idle", err_state, 0);
    send_byte(8'h00);
    send_break();
    send_break();
    check(err_state == 1'b0, "R11 two breaks from error", err_state, 0);
    send_byte(8'hC1);
    send_break();
    send_break();
    do_write(8'hC2, 8'h66);
    check(last_waddr == 16'h0002 && last_wdata == 8'h66 && last_wspace == 2'd2,
          "R11 resync mid command", {last_waddr, last_wdata}, {16'h0002, 8'h66});
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ds_mem[i] = 8'h00;
    for (int i = 0; i < 64; i++)  io_mem[i] = 8'h00;
    for (int i = 0; i < 16; i++)  cs_mem[i] = 8'h00;
    rst_n = 1'b0;
    rx_valid = 1'b0;
    rx_byte = 8'h00;
    rx_parity_err = 1'b0;
    rx_frame_err = 1'b0;
    rx_break = 1'b0;
    tx_collision = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ptr_and_store();
    t_load();
    t_io();
    t_cs();
    t_key(8'h01);
    t_bad_opcode();
    t_parity_mid_write();
    t_collision_read();
    t_frame_in_key();
    t_two_breaks();
    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule